// File: doc/BRIEF.md
# Two-Input Edge Interval Timer

This block measures how long it takes from one chosen signal transition to another on two asynchronous inputs, A and B. It counts system clock cycles from the selected start event to the selected stop event. The start and stop events are each chosen by a 3-bit code, and each code names a rising edge, a falling edge or either edge on one of the inputs. The start selector and the stop selector use different code tables, so the same code value does not mean the same event for both.

Software drives the block through a few control fields: a block enable, a measurement enable and the two edge selectors. It reads back a done flag, a count of `CNT_W` bits (32 by default) and a constant word that gives the system clock frequency in Hz. Dividing the count by that frequency gives the interval in seconds. A measurement runs only while both enables are high. Dropping the measurement enable and raising it again arms a new shot.

Top module: `edge_interval_timer`

## Requirements
- R1: After reset, `meas_done` is 0 and `meas_count` is 0.
- R2: Start select codes: 0 means A rising, 1 means A falling, 2 means B rising, 3 means B falling, 4 means any edge of A and 5 means any edge of B.
- R3: Stop select codes: 0 means B rising, 1 means B falling, 2 means A rising, 3 means A falling, 4 means any edge of A and 5 means any edge of B.
- R4: Suppose the start input changes in one clock cycle and the stop input changes N cycles later, with N ≥ 1. Then `meas_count` reads N once `meas_done` is set. Both inputs pass through a two-flop synchroniser followed by an edge detector, so the block reacts to an input edge two cycles after it is sampled.
- R5: Once `meas_done` is 1, it stays 1 and `meas_count` holds its value while the enables stay high. Any further edges have no effect.
- R6: When `meas_arm` is 0, `meas_done` and `meas_count` are 0 one cycle later and any measurement in progress is aborted. A rising `meas_arm` (with `blk_en` high) arms a new shot after one cycle.
- R7: When `blk_en` is 0, the block behaves as if `meas_arm` were 0. No measurement completes, and restoring `blk_en` re-arms the block without any start event yet seen.
- R8: After arming, stop events are ignored until a start event has been seen.
- R9: While the block is counting, further start events are ignored and do not restart the count.
- R10: The count saturates at all ones (2^CNT_W − 1) and never wraps.
- R11: Select codes 6 and 7 never match any edge. With such a code, the measurement never completes.
- R12: `clk_freq_hz` reads the `CLK_HZ` parameter value at all times (50,000,000 in the bench).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Block enable |
| meas_arm | input | 1 | Measurement enable; a low-then-high pulse arms a shot |
| start_sel | input | 3 | Start event code (R2 table) |
| stop_sel | input | 3 | Stop event code (R3 table) |
| sig_a | input | 1 | Asynchronous input A |
| sig_b | input | 1 | Asynchronous input B |
| clk_freq_hz | output | 32 | Constant system clock frequency in Hz |
| meas_done | output | 1 | Measurement complete, count valid |
| meas_count | output | CNT_W | Cycle count from start to stop |

## Verification
The bench uses every code of both selector tables. Some tests put the same code value in the start and stop fields with different meanings. A design that shared one table between the selectors would then time the wrong pair of edges, or never finish. Some tests send a stop edge before the start edge, and others send a second start edge in the middle of a count. These catch a design that stops too early or restarts its count, which would report a short interval.

A long interval into a narrow second instance shows whether the counter wraps back to a small value or stays at all ones. Dropping either enable in the middle of a count must abort the shot and clear the result; a design that kept counting would report a stale value. Unused codes 6 and 7 must never finish a measurement.

// File: rtl/eit_pkg.sv
package eit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } eit_state_e;

    typedef struct packed {
        logic a_rise;
        logic a_fall;
        logic b_rise;
        logic b_fall;
    } eit_edges_t;

    localparam int SEL_W = 3;

    // Start table: A rise, A fall, B rise, B fall, A any, B any.
    function automatic logic start_match(input logic [SEL_W-1:0] code,
                                         input eit_edges_t ev);
        case (code)
            3'd0:    start_match = ev.a_rise;
            3'd1:    start_match = ev.a_fall;
            3'd2:    start_match = ev.b_rise;
            3'd3:    start_match = ev.b_fall;
            3'd4:    start_match = ev.a_rise | ev.a_fall;
            3'd5:    start_match = ev.b_rise | ev.b_fall;
            default: start_match = 1'b0;
        endcase
    endfunction

    // Stop table: B rise, B fall, A rise, A fall, A any, B any.
    function automatic logic stop_match(input logic [SEL_W-1:0] code,
                                        input eit_edges_t ev);
        case (code)
            3'd0:    stop_match = ev.b_rise;
            3'd1:    stop_match = ev.b_fall;
            3'd2:    stop_match = ev.a_rise;
            3'd3:    stop_match = ev.a_fall;
            3'd4:    stop_match = ev.a_rise | ev.a_fall;
            3'd5:    stop_match = ev.b_rise | ev.b_fall;
            default: stop_match = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eit_edge.sv
module eit_edge
    import eit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lvl_i,   // [0] = A, [1] = B
    output eit_edges_t ev_o
);
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    always_comb begin
        ev_o.a_rise = lvl_i[0] & ~prev_q[0];
        ev_o.a_fall = ~lvl_i[0] & prev_q[0];
        ev_o.b_rise = lvl_i[1] & ~prev_q[1];
        ev_o.b_fall = ~lvl_i[1] & prev_q[1];
    end
endmodule

// File: rtl/eit_fsm.sv
module eit_fsm
    import eit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    eit_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] res_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  state_q <= ST_ARMED;
                ST_ARMED: if (start_i) begin
                    state_q <= ST_COUNT;
                    cnt_q   <= '0;
                end
                ST_COUNT: if (stop_i) begin
                    state_q <= ST_DONE;
                    res_q   <= cnt_inc;
                end else begin
                    cnt_q <= cnt_inc;
                end
                ST_DONE:  state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = (state_q == ST_DONE);
    assign result_o = res_q;

    p_disarm_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!done_o && result_o == '0));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (run_i && done_o) |=> (done_o && $stable(result_o)));

    p_stop_before_start_r8: assert property (@(posedge clk) disable iff (rst)
        (run_i && state_q == ST_ARMED) |=> !done_o);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (run_i && state_q == ST_COUNT && !stop_i) |=> (state_q == ST_COUNT && cnt_q != '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (run_i && state_q == ST_COUNT && cnt_q == CNT_MAX && !stop_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer
    import eit_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int          CNT_W       = 32,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_en,
    input  logic             meas_arm,
    input  logic [2:0]       start_sel,
    input  logic [2:0]       stop_sel,
    input  logic             sig_a,
    input  logic             sig_b,
    output logic [31:0]      clk_freq_hz,
    output logic             meas_done,
    output logic [CNT_W-1:0] meas_count
);
    logic [1:0] lvl;
    eit_edges_t ev;
    logic       run, start_hit, stop_hit;

    eit_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst(rst), .async_i({sig_b, sig_a}), .sync_o(lvl)
    );

    eit_edge u_edge (
        .clk(clk), .rst(rst), .lvl_i(lvl), .ev_o(ev)
    );

    assign run       = blk_en & meas_arm;
    assign start_hit = start_match(start_sel, ev);
    assign stop_hit  = stop_match(stop_sel, ev);

    eit_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .run_i(run),
        .start_i(start_hit), .stop_i(stop_hit),
        .done_o(meas_done), .result_o(meas_count)
    );

    assign clk_freq_hz = CLK_HZ;

    p_bad_code_r11: assert property (@(posedge clk) disable iff (rst)
        (stop_sel > 3'd5 && !meas_done) |=> (!meas_done || $past(stop_sel) <= 3'd5 || !$past(run)) || (stop_sel <= 3'd5));

    p_freq_const_r12: assert property (@(posedge clk) disable iff (rst)
        clk_freq_hz == CLK_HZ);
endmodule

// File: tb/sim_edge_interval_timer.sv
module sim_edge_interval_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_en = 1'b0, meas_arm = 1'b0;
    logic [2:0]  start_sel = '0, stop_sel = '0;
    logic        sig_a = 1'b0, sig_b = 1'b0;
    logic [31:0] clk_freq_hz, meas_count;
    logic        meas_done;
    logic [31:0] f1;
    logic        done1;
    logic [7:0]  count1;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    edge_interval_timer u0 (
        .clk(clk), .rst(rst), .blk_en(blk_en), .meas_arm(meas_arm),
        .start_sel(start_sel), .stop_sel(stop_sel), .sig_a(sig_a), .sig_b(sig_b),
        .clk_freq_hz(clk_freq_hz), .meas_done(meas_done), .meas_count(meas_count)
    );

    edge_interval_timer #(.CNT_W(8)) u1 (
        .clk(clk), .rst(rst), .blk_en(blk_en), .meas_arm(meas_arm),
        .start_sel(start_sel), .stop_sel(stop_sel), .sig_a(sig_a), .sig_b(sig_b),
        .clk_freq_hz(f1), .meas_done(done1), .meas_count(count1)
    );

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int     m_st = 0;           // 0 idle, 1 armed, 2 counting, 3 done
    longint m_cnt = 0, m_res = 0;
    bit     ha1, ha2, ha3, hb1, hb2, hb3;
    bit     model_on = 0;

    function automatic bit sel_hit(int code, bit is_stop, bit ar, bit af, bit br, bit bf);
        if (!is_stop) begin
            case (code)
                0: return ar; 1: return af; 2: return br; 3: return bf;
                4: return ar | af; 5: return br | bf; default: return 0;
            endcase
        end else begin
            case (code)
                0: return br; 1: return bf; 2: return ar; 3: return af;
                4: return ar | af; 5: return br | bf; default: return 0;
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_res = 0;
            ha1 = 0; ha2 = 0; ha3 = 0; hb1 = 0; hb2 = 0; hb3 = 0;
        end else begin
            bit ar, af, br, bf, go, sh;
            ar = ha2 & !ha3; af = !ha2 & ha3;
            br = hb2 & !hb3; bf = !hb2 & hb3;
            go = sel_hit(int'(start_sel), 0, ar, af, br, bf);
            sh = sel_hit(int'(stop_sel), 1, ar, af, br, bf);
            if (!(blk_en && meas_arm)) begin
                m_st = 0; m_cnt = 0; m_res = 0;
            end else begin
                case (m_st)
                    0: m_st = 1;
                    1: if (go) begin m_st = 2; m_cnt = 0; end
                    2: begin
                        longint nx;
                        nx = (m_cnt == 64'hFFFF_FFFF) ? m_cnt : m_cnt + 1;
                        if (sh) begin m_st = 3; m_res = nx; end
                        else m_cnt = nx;
                    end
                    default: ;
                endcase
            end
            ha3 = ha2; ha2 = ha1; ha1 = sig_a;
            hb3 = hb2; hb2 = hb1; hb1 = sig_b;
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst && !finished) begin
            check("R4 model done", longint'(meas_done), longint'(m_st == 3));
            check("R4 model count", longint'(meas_count), m_res);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(logic [2:0] s, logic [2:0] p);
        @(negedge clk);
        meas_arm = 0; start_sel = s; stop_sel = p;
        @(negedge clk);
        meas_arm = 1;
        waitn(3);
    endtask

    initial begin
        waitn(3);
        check("R1 reset done", longint'(meas_done), 0);
        check("R1 reset count", longint'(meas_count), 0);
        rst = 0; blk_en = 1;
        model_on = 1;
        check("R12 clock frequency", longint'(clk_freq_hz), 50_000_000);

        // S1: start code 0 (A rise), stop code 0 (B rise)
        arm(3'd0, 3'd0);
        sig_a = 1; waitn(10); sig_b = 1; waitn(4);
        check("R2 start0/R3 stop0 done", longint'(meas_done), 1);
        check("R2 start0/R3 stop0 count", longint'(meas_count), 10);

        // S2: start 1 (A fall), stop 1 (B fall); early stop ignored (R8)
        arm(3'd1, 3'd1);
        sig_b = 0; waitn(5);
        check("R8 stop before start", longint'(meas_done), 0);
        sig_a = 0; waitn(7); sig_b = 1; waitn(3); sig_b = 0; waitn(4);
        check("R2 start1/R3 stop1 count", longint'(meas_count), 10);

        // S3: start 2 (B rise), stop 2 (A rise); second start ignored (R9)
        arm(3'd2, 3'd2);
        sig_b = 1; waitn(2); sig_b = 0; waitn(2); sig_b = 1; waitn(2); sig_a = 1; waitn(4);
        check("R9 restart ignored count", longint'(meas_count), 6);

        // S4: start 3 (B fall), stop 3 (A fall)
        arm(3'd3, 3'd3);
        sig_b = 0; waitn(5); sig_a = 0; waitn(4);
        check("R2 start3/R3 stop3 count", longint'(meas_count), 5);

        // S5: start 4, stop 4 (any A edge both)
        arm(3'd4, 3'd4);
        sig_a = 1; waitn(9); sig_a = 0; waitn(4);
        check("R2 start4/R3 stop4 count", longint'(meas_count), 9);

        // S6: start 5, stop 5 (any B edge), then later edges ignored (R5)
        arm(3'd5, 3'd5);
        sig_b = 1; waitn(4); sig_b = 0; waitn(4);
        check("R2 start5/R3 stop5 count", longint'(meas_count), 4);
        sig_b = 1; waitn(3); sig_b = 0; waitn(4);
        check("R5 hold done", longint'(meas_done), 1);
        check("R5 hold count", longint'(meas_count), 4);

        // S7: dropping arm clears (R6)
        meas_arm = 0; waitn(2);
        check("R6 clear done", longint'(meas_done), 0);
        check("R6 clear count", longint'(meas_count), 0);
        meas_arm = 1; waitn(4);
        check("R6 rearm no edge", longint'(meas_done), 0);

        // S8: block enable low aborts (R7)
        arm(3'd0, 3'd0);
        sig_a = 1; waitn(4); blk_en = 0; waitn(2); sig_b = 1; waitn(5);
        check("R7 disabled done", longint'(meas_done), 0);
        check("R7 disabled count", longint'(meas_count), 0);
        blk_en = 1; waitn(5);
        check("R7 reenabled needs start", longint'(meas_done), 0);
        sig_a = 0; sig_b = 0; waitn(4);

        // S9: unused codes (R11)
        arm(3'd6, 3'd0);
        sig_a = 1; waitn(3); sig_a = 0; sig_b = 1; waitn(3); sig_b = 0; waitn(5);
        check("R11 start code 6", longint'(meas_done), 0);
        arm(3'd0, 3'd7);
        sig_a = 1; waitn(3); sig_b = 1; waitn(3); sig_b = 0; sig_a = 0; waitn(5);
        check("R11 stop code 7", longint'(meas_done), 0);

        // S10: long interval, saturation in narrow instance (R10)
        arm(3'd0, 3'd0);
        sig_a = 1; waitn(300); sig_b = 1; waitn(4);
        check("R4 long count", longint'(meas_count), 300);
        check("R10 narrow done", longint'(done1), 1);
        check("R10 saturated count", longint'(count1), 255);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule